// File: doc/BRIEF.md
# Order-Preserving Read/Write Request Queue

This block sits between two memory-mapped slave ports, one for reads and one for writes, and a transport transmitter that takes a single stream of requests. Each accepted request becomes a queue entry. A read occupies one entry that carries its burst count. A write occupies one entry per data beat, and each beat is tagged with first-beat and last-beat flags. The transmitter drains the entries through a valid/ready handshake.

A build-time parameter, `ORDERED`, picks between two structures. With `ORDERED=0`, reads and writes go into separate buffers. A round-robin arbiter drains them, so a read and a write that arrive close together may leave in either order. With `ORDERED=1`, both ports feed one shared buffer, and requests leave in exactly the order they were accepted. In the combined mode, a write and a read accepted in the same cycle are stored write first. In both modes a write burst reaches the output as an unbroken run of beats. The block also counts accepted write transactions. Response handling is outside this block, so the read-response outputs stay idle.

Top module: `rw_req_queue`

## Requirements
- R1: After reset, req_valid_o, rd_wait_o and wr_wait_o are 0 and wr_count_o is 0.
- R2: With ORDERED=0, the arbiter alternates between the read and write buffers when both hold requests, and the write buffer wins first after reset. Winning a write means granting all of its beats.
- R3: With ORDERED=0, once the first beat of a multi-beat write leaves, no read leaves until the last beat of that write has left. If the write buffer runs empty in the middle of the burst, req_valid_o is 0 even while reads are waiting.
- R4: With ORDERED=1, entries leave in acceptance order. A write and a read accepted in the same cycle leave write first.
- R5: With ORDERED=1, rd_wait_o is 1 in two cases. The first is while a write burst is open, meaning its first beat has been accepted and its last has not. The second is when a write presented in the same cycle does not complete its burst. A read presented together with the last beat is accepted and stored after it.
- R6: wr_wait_o is 1 when the target buffer has no free entry. rd_wait_o is 1 in two cases: when its own buffer is full (separate mode), or when fewer than two entries are free (combined mode). A request held under wait is not enqueued.
- R7: Each write beat yields one entry with req_is_wr_o=1 and the presented address, data and byte enables. req_first_o=1 only on the first beat of a burst and req_last_o=1 only on its final beat. The burst length is taken from wr_burst_i on the first beat, and a value of 0 counts as 1. A read yields one entry with req_is_wr_o=0, req_first_o=req_last_o=1 and req_burst_o equal to rd_burst_i.
- R8: wr_count_o increments by one for each accepted first beat of a write, and by nothing else.
- R9: While req_valid_o=1 and req_ready_i=0, req_valid_o stays 1 and every req_* payload output holds its value on the next cycle.
- R10: A read or write presented with its chip select low is ignored. Nothing is enqueued and the counter does not change.
- R11: rd_valid_o, rd_err_o and rd_data_o are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_cs_i | input | 1 | Read port chip select |
| rd_read_i | input | 1 | Read request strobe |
| rd_addr_i | input | ADDR_W | Read address |
| rd_burst_i | input | BURST_W | Read burst length |
| rd_wait_o | output | 1 | Read port stall |
| rd_data_o | output | DATA_W | Read data (held 0) |
| rd_valid_o | output | 1 | Read data valid (held 0) |
| rd_err_o | output | 1 | Read error (held 0) |
| wr_cs_i | input | 1 | Write port chip select |
| wr_write_i | input | 1 | Write beat strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_burst_i | input | BURST_W | Write burst length, sampled on the first beat |
| wr_data_i | input | DATA_W | Write data |
| wr_be_i | input | DATA_W/8 | Write byte enables |
| wr_wait_o | output | 1 | Write port stall |
| wr_count_o | output | CNT_W | Accepted write transactions |
| req_valid_o | output | 1 | Output entry valid |
| req_ready_i | input | 1 | Transmitter accepts entry |
| req_is_wr_o | output | 1 | 1 = write beat, 0 = read |
| req_first_o | output | 1 | First entry of a request |
| req_last_o | output | 1 | Last entry of a request |
| req_addr_o | output | ADDR_W | Entry address |
| req_burst_o | output | BURST_W | Entry burst length |
| req_data_o | output | DATA_W | Entry write data |
| req_be_o | output | DATA_W/8 | Entry byte enables |

## Verification
The bench compares the two modes side by side on the same stimulus.

- **Same-cycle arrivals:** a write and a read arrive together. A combined queue that stored the read first, or a separate queue that did not alternate, gives the wrong output order.
- **Empty write buffer mid-burst:** the write buffer is starved between two burst beats while a read waits. An arbiter without a burst lock slips the read between the beats.
- **Read during a combined-mode write burst:** a read is held across the burst. A design with a wrong stall rule either splits the burst or refuses the read on the last beat.
- **Filled queues and chip select:** an extra write is offered to a full queue, and requests are offered with chip select low. A design that drops or double-counts writes, or reacts without chip select, shows a wrong entry count or a wrong counter value.

// File: rtl/rwq_pkg.sv
package rwq_pkg;
  typedef enum logic {KIND_RD = 1'b0, KIND_WR = 1'b1} req_kind_e;
endpackage

// File: rtl/rwq_fifo.sv
module rwq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push0_i,
  input  logic [W-1:0] din0_i,
  input  logic         push1_i,
  input  logic [W-1:0] din1_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic [AW:0]  free_o
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW:0]   cnt_q;

  assign dout_o  = mem[rptr_q];
  assign empty_o = (cnt_q == '0);
  assign free_o  = (AW+1)'(DEPTH) - cnt_q;

  always_ff @(posedge clk_i) begin
    if (push0_i) mem[wptr_q] <= din0_i;
    if (push1_i) mem[wptr_q + AW'(1)] <= din1_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_q + AW'(push0_i) + AW'(push1_i);
      rptr_q <= rptr_q + AW'(pop_i);
      cnt_q  <= cnt_q + (AW+1)'(push0_i) + (AW+1)'(push1_i) - (AW+1)'(pop_i);
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push0_i |-> (free_o != '0));
  assert_dual_push_room_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push1_i |-> (push0_i && free_o > (AW+1)'(1)));
  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/rwq_wr_track.sv
module rwq_wr_track #(
  parameter int BURST_W = 4,
  parameter int CNT_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_i,
  input  logic [BURST_W-1:0] burst_i,
  output logic               first_o,
  output logic               last_o,
  output logic               open_o,
  output logic [CNT_W-1:0]   count_o
);
  logic [BURST_W-1:0] left_q;

  assign first_o = (left_q == '0);
  assign open_o  = !first_o;
  assign last_o  = first_o ? (burst_i <= BURST_W'(1)) : (left_q == BURST_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q  <= '0;
      count_o <= '0;
    end else if (acc_i) begin
      if (first_o) begin
        left_q  <= (burst_i > BURST_W'(1)) ? burst_i - BURST_W'(1) : '0;
        count_o <= count_o + CNT_W'(1);
      end else begin
        left_q <= left_q - BURST_W'(1);
      end
    end
  end

  assert_count_per_txn_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && left_q == '0) |=> count_o == $past(count_o) + CNT_W'(1));
  assert_count_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_i && left_q == '0) |=> $stable(count_o));
endmodule

// File: rtl/rwq_rr_arb.sv
module rwq_rr_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_avail_i,
  input  logic wr_avail_i,
  input  logic wr_last_i,
  input  logic ready_i,
  output logic sel_wr_o,
  output logic valid_o,
  output logic pop_rd_o,
  output logic pop_wr_o
);
  logic prio_wr_q, lock_q, held_q, sel_q;

  always_comb begin
    if (held_q)                       sel_wr_o = sel_q;
    else if (lock_q)                  sel_wr_o = 1'b1;
    else if (rd_avail_i && wr_avail_i) sel_wr_o = prio_wr_q;
    else                              sel_wr_o = wr_avail_i;
  end

  assign valid_o  = sel_wr_o ? wr_avail_i : rd_avail_i;
  assign pop_wr_o = valid_o && ready_i && sel_wr_o;
  assign pop_rd_o = valid_o && ready_i && !sel_wr_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_wr_q <= 1'b1;
      lock_q    <= 1'b0;
      held_q    <= 1'b0;
      sel_q     <= 1'b0;
    end else begin
      held_q <= valid_o && !ready_i;
      sel_q  <= sel_wr_o;
      if (pop_wr_o) begin
        lock_q <= !wr_last_i;
        if (wr_last_i) prio_wr_q <= 1'b0;
      end
      if (pop_rd_o) prio_wr_q <= 1'b1;
    end
  end

  assert_burst_contig_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_wr_o && !wr_last_i) |=> !pop_rd_o);
  assert_rr_after_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_rd_o && ready_i) |=> (rd_avail_i && wr_avail_i && !held_q) |-> sel_wr_o);
endmodule

// File: rtl/rw_req_queue.sv
module rw_req_queue #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int BURST_W = 4,
  parameter int DEPTH   = 8,
  parameter int CNT_W   = 16,
  parameter bit ORDERED = 1'b1,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_cs_i,
  input  logic               rd_read_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  input  logic [BURST_W-1:0] rd_burst_i,
  output logic               rd_wait_o,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               rd_valid_o,
  output logic               rd_err_o,
  input  logic               wr_cs_i,
  input  logic               wr_write_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [BURST_W-1:0] wr_burst_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [BE_W-1:0]    wr_be_i,
  output logic               wr_wait_o,
  output logic [CNT_W-1:0]   wr_count_o,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  output logic               req_is_wr_o,
  output logic               req_first_o,
  output logic               req_last_o,
  output logic [ADDR_W-1:0]  req_addr_o,
  output logic [BURST_W-1:0] req_burst_o,
  output logic [DATA_W-1:0]  req_data_o,
  output logic [BE_W-1:0]    req_be_o
);
  import rwq_pkg::*;

  localparam int ENT_W = 3 + ADDR_W + BURST_W + DATA_W + BE_W;
  localparam int AW    = $clog2(DEPTH);

  logic wr_req, rd_req, wr_acc, rd_acc;
  logic trk_first, trk_last, trk_open;
  logic [ENT_W-1:0] wr_ent, rd_ent, head;
  req_kind_e head_kind;

  assign wr_req = wr_cs_i && wr_write_i;
  assign rd_req = rd_cs_i && rd_read_i;
  assign wr_acc = wr_req && !wr_wait_o;
  assign rd_acc = rd_req && !rd_wait_o;

  assign rd_data_o  = '0;
  assign rd_valid_o = 1'b0;
  assign rd_err_o   = 1'b0;

  rwq_wr_track #(.BURST_W(BURST_W), .CNT_W(CNT_W)) u_track (
    .clk_i, .rst_ni,
    .acc_i  (wr_acc),
    .burst_i(wr_burst_i),
    .first_o(trk_first),
    .last_o (trk_last),
    .open_o (trk_open),
    .count_o(wr_count_o)
  );

  assign wr_ent = {KIND_WR, trk_first, trk_last, wr_addr_i, wr_burst_i, wr_data_i, wr_be_i};
  assign rd_ent = {KIND_RD, 1'b1, 1'b1, rd_addr_i, rd_burst_i, {DATA_W{1'b0}}, {BE_W{1'b0}}};

  generate
    if (ORDERED) begin : g_combined
      logic [AW:0] free;
      logic        empty;
      logic        rd_stall;

      // a read may not split a write burst; it may ride along with the last beat
      assign rd_stall  = wr_req ? !trk_last : trk_open;
      assign wr_wait_o = (free == '0);
      assign rd_wait_o = (free < (AW+1)'(2)) || rd_stall;

      rwq_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk_i, .rst_ni,
        .push0_i(wr_acc || rd_acc),
        .din0_i (wr_acc ? wr_ent : rd_ent),
        .push1_i(wr_acc && rd_acc),
        .din1_i (rd_ent),
        .pop_i  (req_valid_o && req_ready_i),
        .dout_o (head),
        .empty_o(empty),
        .free_o (free)
      );
      assign req_valid_o = !empty;
    end else begin : g_split
      logic [AW:0] rd_free, wr_free;
      logic rd_empty, wr_empty, pop_rd, pop_wr, sel_wr;
      logic [ENT_W-1:0] rd_head, wr_head;

      assign wr_wait_o = (wr_free == '0);
      assign rd_wait_o = (rd_free == '0);

      rwq_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_rd_fifo (
        .clk_i, .rst_ni,
        .push0_i(rd_acc), .din0_i(rd_ent),
        .push1_i(1'b0),   .din1_i('0),
        .pop_i  (pop_rd), .dout_o(rd_head),
        .empty_o(rd_empty), .free_o(rd_free)
      );
      rwq_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_wr_fifo (
        .clk_i, .rst_ni,
        .push0_i(wr_acc), .din0_i(wr_ent),
        .push1_i(1'b0),   .din1_i('0),
        .pop_i  (pop_wr), .dout_o(wr_head),
        .empty_o(wr_empty), .free_o(wr_free)
      );
      rwq_rr_arb u_arb (
        .clk_i, .rst_ni,
        .rd_avail_i(!rd_empty),
        .wr_avail_i(!wr_empty),
        .wr_last_i (wr_head[ENT_W-3]),
        .ready_i   (req_ready_i),
        .sel_wr_o  (sel_wr),
        .valid_o   (req_valid_o),
        .pop_rd_o  (pop_rd),
        .pop_wr_o  (pop_wr)
      );
      assign head = sel_wr ? wr_head : rd_head;
    end
  endgenerate

  assign head_kind = req_kind_e'(head[ENT_W-1]);
  assign req_is_wr_o = (head_kind == KIND_WR);
  assign {req_first_o, req_last_o, req_addr_o, req_burst_o, req_data_o, req_be_o} = head[ENT_W-2:0];

  assert_hold_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_is_wr_o) &&
      $stable(req_addr_o) && $stable(req_data_o) && $stable(req_first_o) &&
      $stable(req_last_o) && $stable(req_burst_o) && $stable(req_be_o)));
  assert_resp_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o && !rd_err_o);
  assert_no_cs_no_count_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cs_i |=> $stable(wr_count_o));
endmodule

// File: tb/sim_rw_req_queue.sv
module sim_rw_req_queue;
  localparam time CLK_P = 10ns;
  localparam int DW = 32, AWD = 32, BW = 4, DEP = 4, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rd_cs, rd_rd0, rd_rd1, wr_cs, wr_wr, rdy0, rdy1;
  logic [AWD-1:0] rd_addr, wr_addr;
  logic [BW-1:0]  rd_burst, wr_burst;
  logic [DW-1:0]  wr_data;
  logic [DW/8-1:0] wr_be;

  logic rw0, ww0, rv0, re0, v0, iw0, f0, l0;
  logic rw1, ww1, rv1, re1, v1, iw1, f1, l1;
  logic [DW-1:0] rdd0, rdd1, d0, d1;
  logic [CW-1:0] cnt0, cnt1;
  logic [AWD-1:0] a0, a1;
  logic [BW-1:0] b0, b1;
  logic [DW/8-1:0] be0, be1;

  rw_req_queue #(.DATA_W(DW), .ADDR_W(AWD), .BURST_W(BW), .DEPTH(DEP), .CNT_W(CW), .ORDERED(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_cs_i(rd_cs), .rd_read_i(rd_rd0), .rd_addr_i(rd_addr), .rd_burst_i(rd_burst),
    .rd_wait_o(rw0), .rd_data_o(rdd0), .rd_valid_o(rv0), .rd_err_o(re0),
    .wr_cs_i(wr_cs), .wr_write_i(wr_wr), .wr_addr_i(wr_addr), .wr_burst_i(wr_burst),
    .wr_data_i(wr_data), .wr_be_i(wr_be), .wr_wait_o(ww0), .wr_count_o(cnt0),
    .req_valid_o(v0), .req_ready_i(rdy0), .req_is_wr_o(iw0), .req_first_o(f0),
    .req_last_o(l0), .req_addr_o(a0), .req_burst_o(b0), .req_data_o(d0), .req_be_o(be0));

  rw_req_queue #(.DATA_W(DW), .ADDR_W(AWD), .BURST_W(BW), .DEPTH(DEP), .CNT_W(CW), .ORDERED(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_cs_i(rd_cs), .rd_read_i(rd_rd1), .rd_addr_i(rd_addr), .rd_burst_i(rd_burst),
    .rd_wait_o(rw1), .rd_data_o(rdd1), .rd_valid_o(rv1), .rd_err_o(re1),
    .wr_cs_i(wr_cs), .wr_write_i(wr_wr), .wr_addr_i(wr_addr), .wr_burst_i(wr_burst),
    .wr_data_i(wr_data), .wr_be_i(wr_be), .wr_wait_o(ww1), .wr_count_o(cnt1),
    .req_valid_o(v1), .req_ready_i(rdy1), .req_is_wr_o(iw1), .req_first_o(f1),
    .req_last_o(l1), .req_addr_o(a1), .req_burst_o(b1), .req_data_o(d1), .req_be_o(be1));

  // output logs
  logic lw0 [64], lf0 [64], ll0 [64], lw1 [64], lf1 [64], ll1 [64];
  int   la0 [64], lb0 [64], la1 [64], lb1 [64];
  int n0 = 0, n1 = 0;
  always @(posedge clk) begin
    if (rst_n && v0 && rdy0) begin
      lw0[n0%64] <= iw0; lf0[n0%64] <= f0; ll0[n0%64] <= l0;
      la0[n0%64] <= int'(a0); lb0[n0%64] <= int'(b0); n0 <= n0 + 1;
    end
    if (rst_n && v1 && rdy1) begin
      lw1[n1%64] <= iw1; lf1[n1%64] <= f1; ll1[n1%64] <= l1;
      la1[n1%64] <= int'(a1); lb1[n1%64] <= int'(b1); n1 <= n1 + 1;
    end
  end

  int nchk = 0, nerr = 0;
  int exp_cnt = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_ent(int inst, int idx, bit wr, int addr, bit fi, bit la, int bu, string tag);
    int got_w, got_a, got_f, got_l, got_b;
    if (inst == 0) begin
      got_w = lw0[idx]; got_a = la0[idx]; got_f = lf0[idx]; got_l = ll0[idx]; got_b = lb0[idx];
    end else begin
      got_w = lw1[idx]; got_a = la1[idx]; got_f = lf1[idx]; got_l = ll1[idx]; got_b = lb1[idx];
    end
    chk(tag, $sformatf("u%0d entry %0d {wr,addr,first,last,burst}", inst, idx),
        (got_w << 28) | (got_a << 12) | (got_f << 9) | (got_l << 8) | got_b,
        (int'(wr) << 28) | (addr << 12) | (int'(fi) << 9) | (int'(la) << 8) | bu);
  endtask

  task automatic idle();
    rd_cs = 0; rd_rd0 = 0; rd_rd1 = 0; wr_cs = 0; wr_wr = 0;
  endtask

  task automatic put_wr(int addr, int burst);
    wr_cs = 1; wr_wr = 1; wr_addr = AWD'(addr); wr_burst = BW'(burst);
    wr_data = DW'(addr * 3); wr_be = '1;
  endtask

  task automatic put_rd(bit to0, bit to1, int addr, int burst);
    rd_cs = 1; rd_rd0 = to0; rd_rd1 = to1; rd_addr = AWD'(addr); rd_burst = BW'(burst);
  endtask

  task automatic drain(int cycles);
    rdy0 = 1; rdy1 = 1;
    repeat (cycles) @(negedge clk);
    rdy0 = 0; rdy1 = 0;
  endtask

  task automatic t_reset();
    chk("R1", "u0 valid", v0, 0);   chk("R1", "u1 valid", v1, 0);
    chk("R1", "u0 waits", {rw0, ww0}, 0); chk("R1", "u1 waits", {rw1, ww1}, 0);
    chk("R1", "counts", cnt0 | cnt1, 0);
    chk("R11", "resp outputs", int'(rv0) | int'(re0) | int'(rdd0) | int'(rv1) | int'(re1) | int'(rdd1), 0);
  endtask

  task automatic t_order();
    int s0 = n0, s1 = n1;
    @(negedge clk); put_wr('h10, 1); put_rd(1, 1, 'h20, 1);
    #1 chk("R6", "waits with room", {rw0, ww0, rw1, ww1}, 0);
    @(negedge clk); wr_cs = 0; wr_wr = 0; put_rd(1, 1, 'h30, 1);
    @(negedge clk); idle(); put_wr('h40, 1);
    @(negedge clk); idle();
    exp_cnt += 2;
    chk("R9", "u0 head before stall", int'(a0), 'h10);
    @(negedge clk);
    chk("R9", "u0 head held", int'(a0), 'h10);
    chk("R2", "u1 first grant is write", int'(iw1), 1);
    drain(8);
    chk("R4", "u0 entries", n0 - s0, 4);
    chk_ent(0, s0,   1, 'h10, 1, 1, 1, "R4");
    chk_ent(0, s0+1, 0, 'h20, 1, 1, 1, "R4");
    chk_ent(0, s0+2, 0, 'h30, 1, 1, 1, "R4");
    chk_ent(0, s0+3, 1, 'h40, 1, 1, 1, "R4");
    chk("R2", "u1 entries", n1 - s1, 4);
    chk_ent(1, s1,   1, 'h10, 1, 1, 1, "R2");
    chk_ent(1, s1+1, 0, 'h20, 1, 1, 1, "R2");
    chk_ent(1, s1+2, 1, 'h40, 1, 1, 1, "R2");
    chk_ent(1, s1+3, 0, 'h30, 1, 1, 1, "R2");
  endtask

  task automatic t_burst_lock();
    int s0 = n0, s1 = n1;
    rdy1 = 1; rdy0 = 0;
    @(negedge clk); put_wr('h50, 3); put_rd(0, 1, 'h60, 5);
    @(negedge clk); idle();
    @(negedge clk);
    chk("R3", "u1 valid low while burst starved", int'(v1), 0);
    put_wr('h51, 3);
    @(negedge clk); put_wr('h52, 3);
    @(negedge clk); idle();
    repeat (4) @(negedge clk);
    rdy1 = 0;
    exp_cnt += 1;
    chk("R3", "u1 entries", n1 - s1, 4);
    chk_ent(1, s1,   1, 'h50, 1, 0, 3, "R7");
    chk_ent(1, s1+1, 1, 'h51, 0, 0, 3, "R3");
    chk_ent(1, s1+2, 1, 'h52, 0, 1, 3, "R3");
    chk_ent(1, s1+3, 0, 'h60, 1, 1, 5, "R7");
    chk("R8", "u1 count", int'(cnt1), exp_cnt);
    drain(5);
    chk("R7", "u0 entries", n0 - s0, 3);
    chk_ent(0, s0,   1, 'h50, 1, 0, 3, "R7");
    chk_ent(0, s0+2, 1, 'h52, 0, 1, 3, "R7");
  endtask

  task automatic t_ordered_stall();
    int s0 = n0, s1 = n1;
    @(negedge clk); put_wr('h80, 3); put_rd(1, 0, 'h90, 1);
    #1 chk("R5", "rd_wait with opening burst", int'(rw0), 1);
    @(negedge clk); wr_cs = 0; wr_wr = 0;
    #1 chk("R5", "rd_wait in burst gap", int'(rw0), 1);
    @(negedge clk); put_wr('h81, 3);
    #1 chk("R5", "rd_wait mid beat", int'(rw0), 1);
    @(negedge clk); put_wr('h82, 3);
    #1 chk("R5", "rd_wait on last beat", int'(rw0), 0);
    @(negedge clk); idle();
    exp_cnt += 1;
    drain(8);
    chk("R5", "u0 entries", n0 - s0, 4);
    chk_ent(0, s0,   1, 'h80, 1, 0, 3, "R5");
    chk_ent(0, s0+2, 1, 'h82, 0, 1, 3, "R5");
    chk_ent(0, s0+3, 0, 'h90, 1, 1, 1, "R5");
    chk("R5", "u1 entries", n1 - s1, 3);
  endtask

  task automatic t_full();
    int s0 = n0, s1 = n1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); put_wr('hA0 + i, 1);
      #1 chk("R6", $sformatf("wr_wait beat %0d", i), {ww0, ww1}, 0);
      if (i == 3) chk("R6", "u0/u1 rd_wait with one free", {rw0, rw1}, 2);
    end
    @(negedge clk); put_wr('hA4, 1);
    #1 chk("R6", "wr_wait full", {ww0, ww1}, 3);
    chk("R6", "u0 rd_wait full", int'(rw0), 1);
    @(negedge clk);
    #1 chk("R6", "wr_wait still full", {ww0, ww1}, 3);
    @(negedge clk); idle();
    exp_cnt += 4;
    chk("R8", "u0 count after full", int'(cnt0), exp_cnt);
    drain(8);
    chk("R6", "u0 entries", n0 - s0, 4);
    chk("R6", "u1 entries", n1 - s1, 4);
    chk_ent(0, s0+3, 1, 'hA3, 1, 1, 1, "R6");
    chk_ent(1, s1+3, 1, 'hA3, 1, 1, 1, "R6");
  endtask

  task automatic t_no_cs();
    int s0 = n0, s1 = n1;
    rdy0 = 1; rdy1 = 1;
    @(negedge clk); put_wr('hB0, 1); wr_cs = 0; put_rd(1, 1, 'hB1, 1); rd_cs = 0;
    repeat (3) @(negedge clk);
    idle();
    repeat (3) @(negedge clk);
    rdy0 = 0; rdy1 = 0;
    chk("R10", "entries without cs", (n0 - s0) + (n1 - s1), 0);
    chk("R10", "u0 count", int'(cnt0), exp_cnt);
    chk("R10", "u1 count", int'(cnt1), exp_cnt);
    chk("R11", "resp outputs", int'(rv0) | int'(re0) | int'(rv1) | int'(re1), 0);
  endtask

  initial begin
    idle(); rdy0 = 0; rdy1 = 0;
    rd_addr = '0; wr_addr = '0; rd_burst = '0; wr_burst = '0; wr_data = '0; wr_be = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_order();
    t_burst_lock();
    t_ordered_stall();
    t_full();
    t_no_cs();
    chk("R8", "final u0 count", int'(cnt0), exp_cnt);
    chk("R8", "final u1 count", int'(cnt1), exp_cnt);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule